// File: doc/BRIEF.md
# Pseudo-SRAM Power-Mode Controller

This controller sits between an SRAM-style host bus and a self-refreshing DRAM array. It follows the host's chip select, sleep, byte-enable, output-enable and write-enable pins and moves through six states: power-on wait, initial, active, standby, deep power-down and wake-up recovery. From the same pins it builds a read enable and a write enable for each byte lane of the array. The lower enable covers data bits 7:0 and the upper enable covers bits 15:8.

Two timed waits hold off every access: one after power is applied and one after leaving deep power-down. Both waits are cycle counters whose length comes from the clock frequency and a time in microseconds. Deep power-down stops refresh and drops the array contents. A data-valid flag tells the system whether the array still holds data written since the last deep power-down. A sticky flag records any access attempted during a wait.

Top module: `psram_pwr_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (power-on). The encodings are 0 power-on, 1 initial, 2 active, 3 standby, 4 deep power-down and 5 recovery. The controller moves to initial only after WAIT_CYC consecutive cycles with cs_ni high. A cycle with cs_ni low restarts that count.
- R2: From initial or standby, the controller enters active on the next cycle when cs_ni is low, sleep_ni is high and at least one of ub_ni or lb_ni is low.
- R3: From active, the controller enters standby when cs_ni is high with sleep_ni high, or when both ub_ni and lb_ni are high. In standby, refresh_en_o stays 1 and data_valid_o keeps its value.
- R4: From initial, active or standby, cs_ni high with sleep_ni low enters deep power-down on the next cycle. In deep power-down, refresh_en_o is 0 and data_valid_o is 0.
- R5: Deep power-down lasts at least SLEEP_CYC cycles. It moves to recovery only once that count is reached and sleep_ni is high. Recovery lasts WAIT_CYC cycles and then enters standby. busy_o is 1 in power-on, deep power-down and recovery, and no lane enable is raised while busy_o is 1. refresh_en_o is 0 in power-on.
- R6: Bit 0 of rd_lane_o follows lb_ni and bit 1 follows ub_ni. A lane reads when it is not busy, cs_ni and oe_ni are low, we_ni is high and that lane's byte enable is low. With oe_ni high, rd_lane_o is 0.
- R7: A lane's bit in wr_lane_o is 1 when it is not busy, cs_ni and we_ni are low and that lane's byte enable is low. A write ends in the first cycle in which either cs_ni or we_ni is high. A write suppresses the read on the same lane.
- R8: data_valid_o is 0 after reset. It becomes 1 in the cycle after a write ends, meaning wr_lane_o goes from non-zero to zero. If deep power-down is entered in that same cycle, data_valid_o stays 0.
- R9: An access attempt during power-on or recovery sets violation_o, and only reset clears it. An access attempt is cs_ni low with ub_ni or lb_ni low. The attempt raises no lane enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sleep_ni | input | 1 | Sleep request, active low |
| ub_ni | input | 1 | Upper byte enable, active low |
| lb_ni | input | 1 | Lower byte enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| rd_lane_o | output | 2 | Per-lane read enable to the array (bit 0 lower) |
| wr_lane_o | output | 2 | Per-lane write enable to the array (bit 0 lower) |
| busy_o | output | 1 | Accesses blocked by a wait or deep power-down |
| data_valid_o | output | 1 | Array contents are valid |
| refresh_en_o | output | 1 | Internal refresh permitted |
| violation_o | output | 1 | Sticky: access attempted during a wait |
| mode_o | output | 3 | Current state code |

## Verification
The end of a write and entry into deep power-down can fall in the same cycle. The bench provokes this by ending an active write with chip select rising while sleep is already low. It judges the outcome by requiring data-valid to stay low on the next cycle rather than being set by the completed write. A second collision is an access attempt while a wait is counting. Here the bench checks that the counter restart, the sticky flag and the absence of any lane enable all take effect together, judged against its own model every clock.

// File: rtl/psram_pm_pkg.sv
package psram_pm_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_PON     = 3'd0,
    PM_INIT    = 3'd1,
    PM_ACTIVE  = 3'd2,
    PM_STANDBY = 3'd3,
    PM_DEEP    = 3'd4,
    PM_RECOVER = 3'd5
  } pm_state_e;
endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // saturates at LAST; clear has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (en_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/psram_lane_decode.sv
module psram_lane_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic             allow_i,
  input  logic             cs_ni,
  input  logic             oe_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] be_ni,
  output logic [LANES-1:0] rd_o,
  output logic [LANES-1:0] wr_o
);
  logic sel;
  assign sel = allow_i & ~cs_ni;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_o[g] = sel & ~we_ni & ~be_ni[g];
    assign rd_o[g] = sel &  we_ni & ~oe_ni & ~be_ni[g];
  end
endmodule

// File: rtl/psram_pm_fsm.sv
module psram_pm_fsm
  import psram_pm_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sleep_ni,
  input  logic [LANES-1:0] be_ni,
  input  logic             wait_done_i,
  input  logic             sleep_done_i,
  input  logic             wr_any_i,
  output pm_state_e        state_o,
  output logic             tmr_clr_o,
  output logic             wait_en_o,
  output logic             sleep_en_o,
  output logic             busy_o,
  output logic             refresh_en_o,
  output logic             data_valid_o,
  output logic             violation_o
);
  pm_state_e state_q, state_d;
  logic      wr_any_q, valid_q, viol_q;
  logic      any_be, no_be, access, go_deep, dpd_entry, wr_done, in_wait;

  assign any_be  = ~(&be_ni);
  assign no_be   = &be_ni;
  assign access  = ~cs_ni & any_be;
  assign go_deep = cs_ni & ~sleep_ni;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_PON:     if (wait_done_i && cs_ni) state_d = PM_INIT;
      PM_INIT,
      PM_STANDBY: begin
        if (go_deep)                           state_d = PM_DEEP;
        else if (!cs_ni && sleep_ni && any_be) state_d = PM_ACTIVE;
      end
      PM_ACTIVE: begin
        if (go_deep)             state_d = PM_DEEP;
        else if (cs_ni || no_be) state_d = PM_STANDBY;
      end
      PM_DEEP:    if (sleep_done_i && sleep_ni) state_d = PM_RECOVER;
      PM_RECOVER: if (wait_done_i) state_d = PM_STANDBY;
      default:    state_d = PM_PON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PM_PON;
    else         state_q <= state_d;
  end

  assign in_wait    = (state_q == PM_PON) || (state_q == PM_RECOVER);
  // power-on wait needs an unbroken run of deselected cycles
  assign tmr_clr_o  = (state_d != state_q) || (state_q == PM_PON && !cs_ni);
  assign wait_en_o  = (state_q == PM_PON && cs_ni) || (state_q == PM_RECOVER);
  assign sleep_en_o = (state_q == PM_DEEP);

  assign dpd_entry = (state_d == PM_DEEP) && (state_q != PM_DEEP);
  assign wr_done   = wr_any_q & ~wr_any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_any_q <= 1'b0;
      valid_q  <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      wr_any_q <= wr_any_i;
      if (dpd_entry)    valid_q <= 1'b0;
      else if (wr_done) valid_q <= 1'b1;
      if (in_wait && access) viol_q <= 1'b1;
    end
  end

  assign state_o      = state_q;
  assign busy_o       = in_wait || (state_q == PM_DEEP);
  assign refresh_en_o = (state_q != PM_PON) && (state_q != PM_DEEP);
  assign data_valid_o = valid_q;
  assign violation_o  = viol_q;
endmodule

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
  import psram_pm_pkg::*;
#(
  parameter int unsigned CLK_FREQ_KHZ = 250000,
  parameter int unsigned WAIT_US      = 200,
  parameter int unsigned SLEEP_US     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sleep_ni,
  input  logic              ub_ni,
  input  logic              lb_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  output logic [1:0]        rd_lane_o,
  output logic [1:0]        wr_lane_o,
  output logic              busy_o,
  output logic              data_valid_o,
  output logic              refresh_en_o,
  output logic              violation_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int unsigned LANES     = 2;
  localparam int unsigned WAIT_RAW  = CLK_FREQ_KHZ * WAIT_US / 1000;
  localparam int unsigned SLEEP_RAW = CLK_FREQ_KHZ * SLEEP_US / 1000;
  localparam int unsigned WAIT_CYC  = (WAIT_RAW  > 0) ? WAIT_RAW  : 1;
  localparam int unsigned SLEEP_CYC = (SLEEP_RAW > 0) ? SLEEP_RAW : 1;

  logic [LANES-1:0] be_n, rd, wr;
  logic             wait_done, sleep_done, tmr_clr, wait_en, sleep_en, busy;
  pm_state_e        state;

  assign be_n = {ub_ni, lb_ni};

  psram_wait_timer #(.LIMIT(WAIT_CYC)) u_wait_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (wait_en),
    .done_o (wait_done)
  );

  psram_wait_timer #(.LIMIT(SLEEP_CYC)) u_sleep_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (sleep_en),
    .done_o (sleep_done)
  );

  psram_pm_fsm #(.LANES(LANES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .sleep_ni     (sleep_ni),
    .be_ni        (be_n),
    .wait_done_i  (wait_done),
    .sleep_done_i (sleep_done),
    .wr_any_i     (|wr),
    .state_o      (state),
    .tmr_clr_o    (tmr_clr),
    .wait_en_o    (wait_en),
    .sleep_en_o   (sleep_en),
    .busy_o       (busy),
    .refresh_en_o (refresh_en_o),
    .data_valid_o (data_valid_o),
    .violation_o  (violation_o)
  );

  psram_lane_decode #(.LANES(LANES)) u_lanes (
    .allow_i (~busy),
    .cs_ni   (cs_ni),
    .oe_ni   (oe_ni),
    .we_ni   (we_ni),
    .be_ni   (be_n),
    .rd_o    (rd),
    .wr_o    (wr)
  );

  assign rd_lane_o = rd;
  assign wr_lane_o = wr;
  assign busy_o    = busy;
  assign mode_o    = state;
endmodule

// File: rtl/psram_pwr_ctrl_chk.sv
module psram_pwr_ctrl_chk
  import psram_pm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sleep_ni,
  input logic              oe_ni,
  input logic [1:0]        rd_lane_o,
  input logic [1:0]        wr_lane_o,
  input logic              busy_o,
  input logic              data_valid_o,
  input logic              refresh_en_o,
  input logic              violation_o,
  input logic [MODE_W-1:0] mode_o
);
  AST_PON_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == PM_PON && !cs_ni) |=> (mode_o == PM_PON)); // R1

  AST_DEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == PM_INIT || mode_o == PM_ACTIVE || mode_o == PM_STANDBY) && cs_ni && !sleep_ni)
    |=> (mode_o == PM_DEEP && !data_valid_o)); // R4

  AST_DEEP_NO_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == PM_DEEP) |-> !refresh_en_o); // R4

  AST_RECOVER_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == PM_RECOVER) |=> (mode_o == PM_RECOVER || mode_o == PM_STANDBY)); // R5

  AST_BUSY_NO_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rd_lane_o == 2'b00 && wr_lane_o == 2'b00)); // R5

  AST_OE_HIGH_NO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (rd_lane_o == 2'b00)); // R6

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_lane_o & wr_lane_o) == 2'b00)); // R7

  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |=> violation_o); // R9
endmodule

bind psram_pwr_ctrl psram_pwr_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .sleep_ni     (sleep_ni),
  .oe_ni        (oe_ni),
  .rd_lane_o    (rd_lane_o),
  .wr_lane_o    (wr_lane_o),
  .busy_o       (busy_o),
  .data_valid_o (data_valid_o),
  .refresh_en_o (refresh_en_o),
  .violation_o  (violation_o),
  .mode_o       (mode_o)
);

// File: tb/psram_pwr_ctrl_tb.sv
module psram_pwr_ctrl_tb;
  localparam int KHZ = 1000;
  localparam int WUS = 30;
  localparam int SUS = 8;
  localparam int W   = KHZ * WUS / 1000;
  localparam int S   = KHZ * SUS / 1000;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic cs_ni = 1'b1, sleep_ni = 1'b1, ub_ni = 1'b1, lb_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [1:0] rd_lane_o, wr_lane_o;
  logic busy_o, data_valid_o, refresh_en_o, violation_o;
  logic [2:0] mode_o;

  always #2 clk = ~clk;

  psram_pwr_ctrl #(.CLK_FREQ_KHZ(KHZ), .WAIT_US(WUS), .SLEEP_US(SUS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sleep_ni(sleep_ni),
    .ub_ni(ub_ni), .lb_ni(lb_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .rd_lane_o(rd_lane_o), .wr_lane_o(wr_lane_o), .busy_o(busy_o),
    .data_valid_o(data_valid_o), .refresh_en_o(refresh_en_o),
    .violation_o(violation_o), .mode_o(mode_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  // reference model: 0 pon 1 init 2 active 3 standby 4 deep 5 recover
  int ms = 0, mc = 0;
  bit mv = 0, mvi = 0, mwp = 0;

  function automatic bit m_allow(int s);
    return (s == 1 || s == 2 || s == 3);
  endfunction

  function automatic logic [1:0] m_wr(int s);
    logic [1:0] r;
    r[0] = m_allow(s) && !cs_ni && !we_ni && !lb_ni;
    r[1] = m_allow(s) && !cs_ni && !we_ni && !ub_ni;
    return r;
  endfunction

  function automatic logic [1:0] m_rd(int s);
    logic [1:0] r;
    r[0] = m_allow(s) && !cs_ni && we_ni && !oe_ni && !lb_ni;
    r[1] = m_allow(s) && !cs_ni && we_ni && !oe_ni && !ub_ni;
    return r;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ms = 0; mc = 0; mv = 0; mvi = 0; mwp = 0;
    end else begin
      int  ns;
      bit  wr_now, acc;
      wr_now = |m_wr(ms);
      acc    = !cs_ni && (!ub_ni || !lb_ni);
      ns = ms;
      case (ms)
        0: begin
          if (acc) mvi = 1;
          if (!cs_ni) mc = 0;
          else if (mc == W - 1) ns = 1;
          else mc++;
        end
        1, 3: begin
          if (cs_ni && !sleep_ni) ns = 4;
          else if (!cs_ni && sleep_ni && (!ub_ni || !lb_ni)) ns = 2;
        end
        2: begin
          if (cs_ni && !sleep_ni) ns = 4;
          else if (cs_ni || (ub_ni && lb_ni)) ns = 3;
        end
        4: begin
          if (mc == S - 1) begin
            if (sleep_ni) ns = 5;
          end else mc++;
        end
        5: begin
          if (acc) mvi = 1;
          if (mc == W - 1) ns = 3;
          else mc++;
        end
        default: ns = 0;
      endcase
      if (ns == 4 && ms != 4) mv = 0;
      else if (mwp && !wr_now) mv = 1;
      mwp = wr_now;
      if (ns != ms) mc = 0;
      ms = ns;
    end
  end

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R1 R2 R3 R4 R5 mode", {1'b0, mode_o}, ms[3:0]);
      chk("R6 rd_lane", {2'b0, rd_lane_o}, {2'b0, m_rd(ms)});
      chk("R7 wr_lane", {2'b0, wr_lane_o}, {2'b0, m_wr(ms)});
      chk("R5 busy", {3'b0, busy_o}, {3'b0, !m_allow(ms)});
      chk("R3 R4 refresh", {3'b0, refresh_en_o}, {3'b0, (ms != 0 && ms != 4)});
      chk("R8 data_valid", {3'b0, data_valid_o}, {3'b0, mv});
      chk("R9 violation", {3'b0, violation_o}, {3'b0, mvi});
    end
  end

  task automatic drive(input logic cs, sl, ub, lb, oe, we, input int n);
    cs_ni = cs; sleep_ni = sl; ub_ni = ub; lb_ni = lb; oe_ni = oe; we_ni = we;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic point(input string tag, input logic [3:0] got, input logic [3:0] exp);
    @(negedge clk);
    chk(tag, got, exp);
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk("R1 reset mode", {1'b0, mode_o}, 4'd0);
    chk("R1 reset busy", {3'b0, busy_o}, 4'd1);
    // R1 power-on wait with a restart (cs low, no byte enable: no violation)
    drive(1, 1, 1, 1, 1, 1, 10);
    drive(0, 1, 1, 1, 1, 1, 1);
    drive(1, 1, 1, 1, 1, 1, W - 2);
    chk("R1 still waiting", {1'b0, mode_o}, 4'd0);
    drive(1, 1, 1, 1, 1, 1, 6);
    chk("R1 initial reached", {1'b0, mode_o}, 4'd1);
    // R2 R7 lower-lane write, ended by we
    drive(0, 1, 1, 0, 1, 0, 3);
    drive(0, 1, 1, 0, 1, 1, 1);
    chk("R8 valid after write", {3'b0, data_valid_o}, 4'd1);
    // R6 reads
    drive(0, 1, 0, 0, 0, 1, 2);
    drive(0, 1, 0, 1, 0, 1, 1);
    drive(0, 1, 0, 0, 1, 1, 1);
    // R7 upper write ended by cs, R3 standby
    drive(0, 1, 0, 1, 1, 0, 2);
    drive(1, 1, 1, 1, 1, 1, 3);
    chk("R3 standby", {1'b0, mode_o}, 4'd3);
    drive(0, 1, 1, 0, 1, 1, 2);
    drive(0, 1, 1, 1, 1, 1, 2);
    chk("R3 both lanes off", {1'b0, mode_o}, 4'd3);
    // R4 R8 write end and deep entry in the same cycle
    drive(0, 1, 0, 0, 1, 0, 2);
    drive(1, 0, 1, 1, 1, 1, 1);
    point("R8 collision valid", {3'b0, data_valid_o}, 4'd0);
    drive(1, 0, 1, 1, 1, 1, 1);
    // R5 early sleep release ignored
    drive(1, 1, 1, 1, 1, 1, 1);
    chk("R5 min sleep", {1'b0, mode_o}, 4'd4);
    drive(1, 0, 1, 1, 1, 1, 2);
    drive(0, 0, 0, 0, 0, 1, 2);
    drive(1, 1, 1, 1, 1, 1, 6);
    chk("R5 recovery", {1'b0, mode_o}, 4'd5);
    // R9 access during recovery
    drive(0, 1, 1, 0, 0, 1, 2);
    chk("R9 sticky set", {3'b0, violation_o}, 4'd1);
    drive(1, 1, 1, 1, 1, 1, W + 2);
    chk("R5 back to standby", {1'b0, mode_o}, 4'd3);
    chk("R8 still invalid", {3'b0, data_valid_o}, 4'd0);
    drive(0, 1, 0, 0, 1, 0, 2);
    drive(1, 1, 1, 1, 1, 1, 2);
    chk("R8 valid again", {3'b0, data_valid_o}, 4'd1);
    // second power-up: access in power-on, then deep from initial
    rst_ni = 1'b0;
    @(posedge clk);
    #1 rst_ni = 1'b1;
    chk("R9 cleared by reset", {3'b0, violation_o}, 4'd0);
    drive(0, 1, 1, 0, 1, 0, 2);
    drive(1, 1, 1, 1, 1, 1, W + 2);
    chk("R1 initial after restart", {1'b0, mode_o}, 4'd1);
    drive(1, 0, 1, 1, 1, 1, 2);
    chk("R4 deep from initial", {1'b0, mode_o}, 4'd4);
    drive(1, 0, 1, 1, 1, 1, S);
    drive(1, 1, 1, 1, 1, 1, W + 4);
    chk("R5 standby after recovery", {1'b0, mode_o}, 4'd3);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule